// File: doc/BRIEF.md
# Half-Bridge Dead-Time Gate Sequencer

This block turns a commanded switching period, counted in clock cycles, into two complementary gate enables for a half-bridge: a low-side enable and a high-side enable. Each leg is on for roughly half of the period. A programmable number of dead cycles is left between the fall of either leg and the rise of the other. The dead time is taken out of each half, so one full low/gap/high/gap round lasts exactly the commanded period. Switching always starts on the low side. The high side only fires once its floating supply reports ready.

The block also drives an enable for the switch-node sense switch. That window opens when a high-side phase ends and closes when the following low-side phase ends. A one-cycle strobe marks each low-side rise, for use by the protection logic. A force-off input, or dropping the enable, shuts everything off at the next clock edge. A new period word is accepted only at the start of each low-side phase.

The controller has five states. ST_IDLE has both legs off. ST_LOW_ON has the low leg on. ST_GAP_LH is the dead gap before the high leg. ST_HIGH_ON is the high phase, with the leg on only if the high side was ready. ST_GAP_HL is the dead gap before the low leg. The transitions are:
- T_START: ST_IDLE to ST_LOW_ON, while running.
- T_LOW_END: ST_LOW_ON to ST_GAP_LH.
- T_GAP1_END: ST_GAP_LH to ST_HIGH_ON.
- T_HIGH_END: ST_HIGH_ON to ST_GAP_HL.
- T_GAP2_END: ST_GAP_HL to ST_LOW_ON.
- T_STOP: from any state to ST_IDLE, when the enable is low or force-off is high.

Top module: `hb_deadtime_gen`

## Requirements
- R1: After reset, and on any clock edge where `enable` is sampled low, all four outputs are 0.
- R2: From ST_IDLE, `lo_gate` rises on the first edge that samples `enable`=1 and `force_off`=0. `ho_gate` is never the first leg to go high.
- R3: For a period word P (after R5), `lo_gate` is high for floor(P/2)−D cycles. Then both legs are low for D cycles. The high phase lasts ceil(P/2)−D cycles, followed again by D low cycles. D is `DEAD_CYC`.
- R4: `period_in` is sampled only on the edge that starts a low phase. A change during a round takes effect from the next round.
- R5: A period word below 2·(D+1) is treated as 2·(D+1).
- R6: `hs_ready` is sampled on the edge that enters the high phase. If it is 0, `ho_gate` stays 0 for that whole phase, even if `hs_ready` rises later in the phase, and the low side keeps switching.
- R7: `lo_gate` and `ho_gate` are never high together.
- R8: `force_off`=1 sampled at an edge drives both legs low at that edge, with no pending pulse finished. Once released, switching restarts with a low phase.
- R9: `sense_en` is 1 from the end of each high phase through the end of the following low phase. It is 0 otherwise, including during the first low phase after a start.
- R10: `lo_strobe` is 1 for exactly the first cycle of every low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; low holds the bridge off |
| force_off | input | 1 | Fault kill; low-side and high-side off at next edge |
| hs_ready | input | 1 | High-side floating supply is ready |
| period_in | input | PER_W | Switching period in clock cycles |
| lo_gate | output | 1 | Low-side gate enable |
| ho_gate | output | 1 | High-side gate enable |
| sense_en | output | 1 | Switch-node sense switch enable |
| lo_strobe | output | 1 | One-cycle pulse on each low-side rise |

## Verification
The kill path and the low-phase restart can land on the same edge. That happens when `force_off` rises exactly as a round's second dead gap ends, so the edge that would raise `lo_gate` and fire `lo_strobe` instead samples the kill. The bench provokes this by asserting `force_off` right after the last gap cycle of a round, then expects all outputs to stay at zero instead of a new pulse and strobe. A second case raises `hs_ready` inside a high phase that began with it low; the high leg must stay off for the rest of that phase and turn on only in the next round.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOW_ON  = 3'd1,
        ST_GAP_LH  = 3'd2,
        ST_HIGH_ON = 3'd3,
        ST_GAP_HL  = 3'd4
    } hb_state_e;

endpackage

// File: rtl/hb_period_store.sv
module hb_period_store #(
    parameter int PER_W    = 16,
    parameter int DEAD_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [PER_W-1:0] period_in,
    output logic [PER_W-1:0] lo_len_new,
    output logic [PER_W-1:0] hi_len
);
    localparam logic [PER_W-1:0] MIN_PER = PER_W'(2 * (DEAD_CYC + 1));
    localparam logic [PER_W-1:0] DEAD_V  = PER_W'(DEAD_CYC);

    logic [PER_W-1:0] clamped;
    logic [PER_W-1:0] per_q;

    // R5: floor the period so that each on-phase lasts at least one cycle
    always_comb begin
        clamped    = (period_in < MIN_PER) ? MIN_PER : period_in;
        lo_len_new = (clamped >> 1) - DEAD_V;
        hi_len     = per_q - (per_q >> 1) - DEAD_V;
    end

    // R4: the period word is captured only when a low phase begins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= MIN_PER;
        end else if (take) begin
            per_q <= clamped;
        end
    end

    a_r5_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
        per_q >= MIN_PER);

endmodule

// File: rtl/hb_phase_counter.sv
module hb_phase_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    // R3: a phase that is not reloaded keeps counting down
    a_r3_count_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/hb_gate_fsm.sv
module hb_gate_fsm
    import hb_dt_pkg::*;
#(
    parameter int PER_W    = 16,
    parameter int DEAD_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             force_off,
    input  logic             hs_ready,
    input  logic             phase_done,
    input  logic [PER_W-1:0] lo_len_new,
    input  logic [PER_W-1:0] hi_len,
    output logic             load,
    output logic [PER_W-1:0] load_val,
    output logic             take,
    output logic             lo_q,
    output logic             ho_q,
    output logic             sense_q,
    output logic             strb_q
);
    localparam logic [PER_W-1:0] DEAD_V = PER_W'(DEAD_CYC);

    hb_state_e state, state_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        if (!enable || force_off) begin
            state_n = ST_IDLE;                           // T_STOP
        end else begin
            unique case (state)
                ST_IDLE:    state_n = ST_LOW_ON;         // T_START
                ST_LOW_ON:  if (phase_done) state_n = ST_GAP_LH;  // T_LOW_END
                ST_GAP_LH:  if (phase_done) state_n = ST_HIGH_ON; // T_GAP1_END
                ST_HIGH_ON: if (phase_done) state_n = ST_GAP_HL;  // T_HIGH_END
                ST_GAP_HL:  if (phase_done) state_n = ST_LOW_ON;  // T_GAP2_END
                default:    state_n = ST_IDLE;
            endcase
        end
    end

    // phase length for the counter on every entry into a timed state
    always_comb begin
        load = (state_n != state) && (state_n != ST_IDLE);
        take = load && (state_n == ST_LOW_ON);
        unique case (state_n)
            ST_LOW_ON:  load_val = lo_len_new - 1'b1;
            ST_GAP_LH:  load_val = DEAD_V - 1'b1;
            ST_HIGH_ON: load_val = hi_len - 1'b1;
            ST_GAP_HL:  load_val = DEAD_V - 1'b1;
            default:    load_val = '0;
        endcase
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q    <= 1'b0;
            ho_q    <= 1'b0;
            sense_q <= 1'b0;
            strb_q  <= 1'b0;
        end else begin
            lo_q    <= (state_n == ST_LOW_ON);
            ho_q    <= (state_n == ST_HIGH_ON) &&
                       ((state == ST_HIGH_ON) ? ho_q : hs_ready);
            sense_q <= (state_n == ST_GAP_HL) ||
                       ((state_n == ST_LOW_ON) &&
                        ((state == ST_GAP_HL) || ((state == ST_LOW_ON) && sense_q)));
            strb_q  <= (state_n == ST_LOW_ON) && (state != ST_LOW_ON);
        end
    end

    a_r7_legs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_q && ho_q));

    a_r3_gap_before_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ho_q) |-> !$past(lo_q));

    a_r6_high_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ho_q) |-> $past(hs_ready));

    a_r8_kill_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> (!lo_q && !ho_q));

    a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!lo_q && !ho_q && !sense_q && !strb_q));

    a_r10_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_q) |-> strb_q);

    a_r10_strobe_with_low: assert property (@(posedge clk) disable iff (!rst_n)
        strb_q |-> lo_q);

    a_r9_sense_closes: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lo_q) |-> !sense_q);

    a_r9_sense_opens: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ho_q) && $past(enable) && !$past(force_off)) |-> sense_q);

endmodule

// File: rtl/hb_deadtime_gen.sv
module hb_deadtime_gen #(
    parameter int PER_W    = 16,
    parameter int DEAD_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             force_off,
    input  logic             hs_ready,
    input  logic [PER_W-1:0] period_in,
    output logic             lo_gate,
    output logic             ho_gate,
    output logic             sense_en,
    output logic             lo_strobe
);
    logic             load;
    logic             take;
    logic             phase_done;
    logic [PER_W-1:0] load_val;
    logic [PER_W-1:0] lo_len_new;
    logic [PER_W-1:0] hi_len;

    hb_period_store #(
        .PER_W    (PER_W),
        .DEAD_CYC (DEAD_CYC)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .period_in  (period_in),
        .lo_len_new (lo_len_new),
        .hi_len     (hi_len)
    );

    hb_phase_counter #(
        .CNT_W (PER_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .done     (phase_done)
    );

    hb_gate_fsm #(
        .PER_W    (PER_W),
        .DEAD_CYC (DEAD_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .force_off  (force_off),
        .hs_ready   (hs_ready),
        .phase_done (phase_done),
        .lo_len_new (lo_len_new),
        .hi_len     (hi_len),
        .load       (load),
        .load_val   (load_val),
        .take       (take),
        .lo_q       (lo_gate),
        .ho_q       (ho_gate),
        .sense_q    (sense_en),
        .strb_q     (lo_strobe)
    );

endmodule

// File: tb/hb_deadtime_gen_bench.sv
module hb_deadtime_gen_bench;
    localparam int PER_W   = 16;
    localparam int D       = 4;
    localparam int MIN_PER = 2 * (D + 1);

    typedef struct {
        logic  lo;
        logic  ho;
        logic  se;
        logic  st;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             force_off = 1'b0;
    logic             hs_ready = 1'b0;
    logic [PER_W-1:0] period_in = 16'd20;
    logic             lo_gate, ho_gate, sense_en, lo_strobe;

    exp_t q[$];
    int   vectors = 0;
    int   misses  = 0;
    int   cyc     = 0;

    always #4 clk = ~clk;

    hb_deadtime_gen #(.PER_W(PER_W), .DEAD_CYC(D)) u_hb_deadtime_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .force_off (force_off),
        .hs_ready  (hs_ready),
        .period_in (period_in),
        .lo_gate   (lo_gate),
        .ho_gate   (ho_gate),
        .sense_en  (sense_en),
        .lo_strobe (lo_strobe)
    );

    // monitor: one expected item per cycle, compared away from the rising edge
    always @(negedge clk) begin
        exp_t e;
        logic bad;
        if (q.size() > 0) begin
            e   = q.pop_front();
            bad = 1'b0;
            vectors++;
            if (lo_gate !== e.lo || ho_gate !== e.ho) begin
                $display("FAIL %s legs: lo/ho=%b%b expected %b%b at %0t",
                         e.tag, lo_gate, ho_gate, e.lo, e.ho, $time);
                bad = 1'b1;
            end
            if (sense_en !== e.se) begin
                $display("FAIL R9 sense_en=%b expected %b at %0t", sense_en, e.se, $time);
                bad = 1'b1;
            end
            if (lo_strobe !== e.st) begin
                $display("FAIL R10 lo_strobe=%b expected %b at %0t", lo_strobe, e.st, $time);
                bad = 1'b1;
            end
            if (lo_gate === 1'b1 && ho_gate === 1'b1) begin
                $display("FAIL R7 both legs high: lo/ho=%b%b expected not 11", lo_gate, ho_gate);
                bad = 1'b1;
            end
            if (bad) misses++;
        end
    end

    task automatic push_quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) q.push_back('{1'b0, 1'b0, 1'b0, 1'b0, tag});
    endtask

    // expected round per R3/R5/R6/R9/R10; limit truncates the pushed items
    task automatic gen_round(input int p, input bit hs, input bit first,
                             input string tag, input int limit);
        int pe, lo_len, hi_len, n;
        pe     = (p < MIN_PER) ? MIN_PER : p;
        lo_len = pe / 2 - D;
        hi_len = pe - pe / 2 - D;
        n      = 0;
        for (int i = 0; i < lo_len; i++) begin
            if (n < limit) q.push_back('{1'b1, 1'b0, !first, (i == 0), tag});
            n++;
        end
        for (int i = 0; i < D; i++) begin
            if (n < limit) q.push_back('{1'b0, 1'b0, 1'b0, 1'b0, tag});
            n++;
        end
        for (int i = 0; i < hi_len; i++) begin
            if (n < limit) q.push_back('{1'b0, hs, 1'b0, 1'b0, tag});
            n++;
        end
        for (int i = 0; i < D; i++) begin
            if (n < limit) q.push_back('{1'b0, 1'b0, 1'b1, 1'b0, tag});
            n++;
        end
    endtask

    task automatic drain();
        wait (q.size() == 0);
        #1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state and disabled
        push_quiet(3, "R1");
        drain();

        // R2: first pulse is low side; R3: even period timing
        period_in = 16'd20;
        hs_ready  = 1'b1;
        enable    = 1'b1;
        gen_round(20, 1'b1, 1'b1, "R2", 1000);
        gen_round(20, 1'b1, 1'b0, "R3", 1000);
        drain();

        // R3: odd period gives the extra cycle to the high phase
        period_in = 16'd21;
        gen_round(21, 1'b1, 1'b0, "R3", 1000);
        drain();

        // R4: period change mid-round applies from the next round
        gen_round(21, 1'b1, 1'b0, "R4", 1000);
        gen_round(30, 1'b1, 1'b0, "R4", 1000);
        repeat (3) @(negedge clk);
        #1;
        period_in = 16'd30;
        drain();

        // R5: too-short period is raised to the floor
        period_in = 16'd3;
        gen_round(3, 1'b1, 1'b0, "R5", 1000);
        drain();

        // R6: high side not ready at phase entry, rises inside the phase
        period_in = 16'd20;
        hs_ready  = 1'b0;
        gen_round(20, 1'b0, 1'b0, "R6", 1000);
        wait (q.size() == 9);
        #1;
        hs_ready = 1'b1;
        drain();
        gen_round(20, 1'b1, 1'b0, "R6", 1000);
        drain();

        // R8: kill in the middle of a high pulse
        gen_round(20, 1'b1, 1'b0, "R8", 13);
        drain();
        force_off = 1'b1;
        push_quiet(3, "R8");
        drain();
        force_off = 1'b0;
        gen_round(20, 1'b1, 1'b1, "R8", 1000);
        drain();

        // R8: kill lands on the edge that would start the next low phase
        force_off = 1'b1;
        push_quiet(2, "R8");
        drain();
        force_off = 1'b0;
        gen_round(20, 1'b1, 1'b1, "R2", 1000);
        drain();

        // R1: enable low at a round boundary, then restart on low side
        enable = 1'b0;
        push_quiet(3, "R1");
        drain();
        enable = 1'b1;
        gen_round(20, 1'b1, 1'b1, "R2", 1000);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            misses++;
            $display("FAIL watchdog: cycles=%0d expected completion before 50000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule